// File: doc/BRIEF.md
# Direction-Masked Four-Pin I/O Port

This block is a small pin port placed between a processor register interface and an attached serial peripheral. It holds three registers: a pin value register, a pin direction register and a one-bit read-enable flag. A write to the pin value register passes only the bits configured as outputs to the peripheral. The register then stores whatever value the peripheral returns in the same clock cycle. This lets the peripheral drive its own serial data line back into the stored value.

The processor side uses a write strobe, a read strobe and a two-bit register select. A read result appears on a registered output one clock after the read strobe. Every read returns zero until software sets the enable flag. Once the flag is set, a read of the pin value register shows only the pins configured as inputs. A parameter chooses at build time whether a peripheral is present. Without one, the port stores the masked write value directly.

Top module: `dirmask_gpio`

## Requirements
- R1: Reset is synchronous and active high. After reset the pin value register holds 0000, the direction register holds 1111 (a 1 means output), the enable flag is 0 and `rd_data` is 0000.
- R2: In a cycle with `wr_en` high and `reg_sel` = 00 (pin value), `dev_wr` is high and `dev_out` equals `wr_data` AND direction. `dev_wr` is low in every other cycle.
- R3: With `HAS_DEVICE` = 1, a pin value write stores the `dev_in` value present at that clock edge, not the masked write value.
- R4: With `HAS_DEVICE` = 0, a pin value write stores `wr_data` AND direction, and `dev_in` has no effect.
- R5: While the enable flag is 0, every read returns 0000, whatever the select code.
- R6: While enabled, a read with `reg_sel` = 00 returns the stored pin value AND the inverse of direction.
- R7: A write with `reg_sel` = 01 stores `wr_data` into direction. A write with `reg_sel` = 10 stores `wr_data` bit 0 into the enable flag. Both writes take effect whether or not the flag is set. A read of select 01 returns direction. A read of select 10 returns the flag in bit 0, with zeros above it.
- R8: Select code 11 reads as 0000, and a write to it changes no register.
- R9: `rd_data` is loaded at the clock edge where `rd_en` is high, using the register state before that edge. It holds its value in every cycle where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 00 pin value, 01 direction, 10 enable flag, 11 unused |
| wr_data | input | PIN_W | Write data |
| rd_data | output | PIN_W | Registered read result |
| dev_wr | output | 1 | High during a pin value write cycle |
| dev_out | output | PIN_W | Write data masked by direction, toward the peripheral |
| dev_in | input | PIN_W | Value returned by the peripheral in the same cycle |

## Verification
The bench's peripheral model returns the presented value XORed with a chosen pattern. A design that stored the masked write instead of the returned value would read back the wrong pins. A design that forgot the direction mask would put input-pin bits on `dev_out`. Reads are taken under mixed directions, with the enable flag clear and with select 11. A port that leaked output pins, ignored the enable gate or decoded 11 as a real register would return non-zero data. A second instance with no peripheral shows whether the masked value is stored. Writes to the enable flag with bit 0 clear and other bits set catch a flag taken from the wrong bit.

// File: rtl/dgp_pkg.sv
package dgp_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PINS = 2'b00,
    SEL_DIR  = 2'b01,
    SEL_EN   = 2'b10,
    SEL_NONE = 2'b11
  } dgp_sel_e;
endpackage

// File: rtl/dgp_devlink.sv
module dgp_devlink #(
  parameter int PIN_W      = 4,
  parameter bit HAS_DEVICE = 1'b1
) (
  input  logic [PIN_W-1:0] wr_data,
  input  logic [PIN_W-1:0] dir_q,
  input  logic [PIN_W-1:0] dev_in,
  output logic [PIN_W-1:0] dev_out,
  output logic [PIN_W-1:0] latch_val
);
  logic [PIN_W-1:0] masked;

  assign masked  = wr_data & dir_q;
  assign dev_out = masked;

  generate
    if (HAS_DEVICE) begin : g_dev
      // peripheral answers combinationally; its reply is what gets stored
      assign latch_val = dev_in;
    end else begin : g_nodev
      logic unused_dev_in;
      assign unused_dev_in = ^dev_in;
      assign latch_val     = masked;
    end
  endgenerate
endmodule

// File: rtl/dgp_regfile.sv
module dgp_regfile #(
  parameter int PIN_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  dgp_pkg::dgp_sel_e         sel,
  input  logic [PIN_W-1:0]          wr_data,
  input  logic [PIN_W-1:0]          latch_val,
  output logic [PIN_W-1:0]          pins_q,
  output logic [PIN_W-1:0]          dir_q,
  output logic                      en_q
);
  import dgp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
      dir_q  <= '1;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_PINS: pins_q <= latch_val;
        SEL_DIR:  dir_q  <= wr_data;
        SEL_EN:   en_q   <= wr_data[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/dgp_readback.sv
module dgp_readback #(
  parameter int PIN_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  dgp_pkg::dgp_sel_e    sel,
  input  logic [PIN_W-1:0]     pins_q,
  input  logic [PIN_W-1:0]     dir_q,
  input  logic                 en_q,
  output logic [PIN_W-1:0]     rd_data
);
  import dgp_pkg::*;

  logic [PIN_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (en_q) begin
      unique case (sel)
        SEL_PINS: rd_next = pins_q & ~dir_q;
        SEL_DIR:  rd_next = dir_q;
        SEL_EN:   rd_next = {{(PIN_W-1){1'b0}}, en_q};
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/dirmask_gpio.sv
module dirmask_gpio #(
  parameter int PIN_W      = 4,
  parameter bit HAS_DEVICE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       reg_sel,
  input  logic [PIN_W-1:0] wr_data,
  output logic [PIN_W-1:0] rd_data,
  output logic             dev_wr,
  output logic [PIN_W-1:0] dev_out,
  input  logic [PIN_W-1:0] dev_in
);
  import dgp_pkg::*;

  dgp_sel_e         sel;
  logic [PIN_W-1:0] pins_q;
  logic [PIN_W-1:0] dir_q;
  logic             en_q;
  logic [PIN_W-1:0] latch_val;

  assign sel    = dgp_sel_e'(reg_sel);
  assign dev_wr = wr_en && (sel == SEL_PINS);

  dgp_devlink #(.PIN_W(PIN_W), .HAS_DEVICE(HAS_DEVICE)) u_link (
    .wr_data   (wr_data),
    .dir_q     (dir_q),
    .dev_in    (dev_in),
    .dev_out   (dev_out),
    .latch_val (latch_val)
  );

  dgp_regfile #(.PIN_W(PIN_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .sel       (sel),
    .wr_data   (wr_data),
    .latch_val (latch_val),
    .pins_q    (pins_q),
    .dir_q     (dir_q),
    .en_q      (en_q)
  );

  dgp_readback #(.PIN_W(PIN_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .sel     (sel),
    .pins_q  (pins_q),
    .dir_q   (dir_q),
    .en_q    (en_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/dirmask_gpio_chk.sv
module dirmask_gpio_chk #(
  parameter int PIN_W      = 4,
  parameter bit HAS_DEVICE = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       reg_sel,
  input logic [PIN_W-1:0] wr_data,
  input logic [PIN_W-1:0] rd_data,
  input logic             dev_wr,
  input logic [PIN_W-1:0] dev_out,
  input logic [PIN_W-1:0] dev_in,
  input logic [PIN_W-1:0] pins_q,
  input logic [PIN_W-1:0] dir_q,
  input logic             en_q
);
  // R1: state right after reset release
  a_r1_reset_vals: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pins_q == '0 && dir_q == '1 && !en_q && rd_data == '0));

  // R2: nothing on an input pin reaches the peripheral
  a_r2_mask: assert property (@(posedge clk) disable iff (rst)
    dev_wr |-> ((dev_out & ~dir_q) == '0 && (dev_out & ~wr_data) == '0));

  // R3 / R4: stored value source
  a_r3_latch_dev: assert property (@(posedge clk) disable iff (rst)
    (HAS_DEVICE && wr_en && reg_sel == 2'b00) |=> pins_q == $past(dev_in));

  a_r4_latch_masked: assert property (@(posedge clk) disable iff (rst)
    (!HAS_DEVICE && wr_en && reg_sel == 2'b00) |=> pins_q == $past(wr_data & dir_q));

  // R5: disabled reads are zero
  a_r5_gate: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !en_q) |=> rd_data == '0);

  // R6: data reads never show output pins
  a_r6_inputs_only: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == 2'b00) |=> (rd_data & $past(dir_q)) == '0);

  // R8: unused select leaves state alone
  a_r8_sel_none: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'b11) |=> ($stable(pins_q) && $stable(dir_q) && $stable(en_q)));

  // R9: result held without a read strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind dirmask_gpio dirmask_gpio_chk #(.PIN_W(PIN_W), .HAS_DEVICE(HAS_DEVICE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .reg_sel (reg_sel),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .dev_wr  (dev_wr),
  .dev_out (dev_out),
  .dev_in  (dev_in),
  .pins_q  (pins_q),
  .dir_q   (dir_q),
  .en_q    (en_q)
);

// File: tb/dirmask_gpio_tb.sv
`timescale 1ns/100ps
module dirmask_gpio_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   reg_sel = 2'b00;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] flip = '0;
  logic [W-1:0] rd_data, dev_out, dev_in;
  logic         dev_wr;
  logic [W-1:0] nd_rd_data, nd_dev_out;
  logic         nd_dev_wr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // peripheral model: returns presented value XOR a chosen pattern
  assign dev_in = dev_out ^ flip;

  dirmask_gpio #(.PIN_W(W), .HAS_DEVICE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .dev_wr(dev_wr),
    .dev_out(dev_out), .dev_in(dev_in));

  dirmask_gpio #(.PIN_W(W), .HAS_DEVICE(1'b0)) u_nodev (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(nd_rd_data), .dev_wr(nd_dev_wr),
    .dev_out(nd_dev_out), .dev_in(4'b1111));

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk(rd_data, 4'b0000, "R1 rd_data after reset");
    rd(2'b01, v); chk(v, 4'b0000, "R5 dir read while disabled");
    rd(2'b10, v); chk(v, 4'b0000, "R5 flag read while disabled");
    @(negedge clk);
    wr_data = 4'b1111; #1;
    chk(dev_out, 4'b1111, "R1 direction resets to all outputs");
    chk({3'b000, dev_wr}, 4'b0000, "R2 dev_wr idle");
    wr(2'b10, 4'b0001);
    rd(2'b01, v); chk(v, 4'b1111, "R1 direction reset value");
    rd(2'b10, v); chk(v, 4'b0001, "R7 flag reads in bit 0");
    wr(2'b01, 4'b0000);
    rd(2'b00, v); chk(v, 4'b0000, "R1 pin value reset value");
  endtask

  task automatic t_mask();
    logic [W-1:0] v;
    flip = 4'b0000;
    wr(2'b01, 4'b0101);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 2'b00; wr_data = 4'b1111; #1;
    chk(dev_out, 4'b0101, "R2 dev_out masked by direction");
    chk({3'b000, dev_wr}, 4'b0001, "R2 dev_wr during pin write");
    @(negedge clk);
    wr_en = 1'b0;
    wr(2'b01, 4'b0000);
    rd(2'b00, v); chk(v, 4'b0101, "R3 stored reply equal to masked value");
  endtask

  task automatic t_device();
    logic [W-1:0] v;
    wr(2'b01, 4'b1111);
    flip = 4'b0110;
    wr(2'b00, 4'b1010);
    flip = 4'b0000;
    wr(2'b01, 4'b0000);
    rd(2'b00, v); chk(v, 4'b1100, "R3 stores peripheral reply");
    chk(nd_rd_data, 4'b1010, "R4 no-device instance stores masked write");
  endtask

  task automatic t_inputs();
    logic [W-1:0] v;
    wr(2'b01, 4'b0110);
    rd(2'b00, v); chk(v, 4'b1000, "R6 only input pins visible");
    chk(nd_rd_data, 4'b1000, "R6 no-device instance input pins");
  endtask

  task automatic t_gate();
    logic [W-1:0] v;
    wr(2'b10, 4'b1110);
    rd(2'b00, v); chk(v, 4'b0000, "R5 pin read while disabled");
    rd(2'b01, v); chk(v, 4'b0000, "R5 dir read while disabled");
    rd(2'b10, v); chk(v, 4'b0000, "R7 flag taken from bit 0 only");
    wr(2'b01, 4'b1010);
    wr(2'b10, 4'b0001);
    rd(2'b01, v); chk(v, 4'b1010, "R7 direction written while disabled");
  endtask

  task automatic t_sel_none();
    logic [W-1:0] v;
    wr(2'b11, 4'b0101);
    rd(2'b11, v); chk(v, 4'b0000, "R8 select 11 reads zero");
    rd(2'b01, v); chk(v, 4'b1010, "R8 direction untouched");
    rd(2'b10, v); chk(v, 4'b0001, "R8 flag untouched");
    wr(2'b01, 4'b0000);
    rd(2'b00, v); chk(v, 4'b1100, "R8 pin value untouched");
  endtask

  task automatic t_hold();
    logic [W-1:0] v;
    wr(2'b01, 4'b0011);
    chk(rd_data, 4'b1100, "R9 held across writes");
    @(negedge clk);
    rd_en = 1'b1; reg_sel = 2'b01; #1;
    chk(rd_data, 4'b1100, "R9 no change before the edge");
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data, 4'b0011, "R9 loaded one clock after strobe");
    repeat (3) @(negedge clk);
    chk(rd_data, 4'b0011, "R9 held while idle");
    rd(2'b00, v); chk(v, 4'b1100, "R6 mixed direction read");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_device();
    t_inputs();
    t_gate();
    t_sel_none();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule